// File: doc/BRIEF.md
# Deferred Prefetch Request Queue

This block sits between a prefetch address generator and the memory-side request port of a cache. It holds a bounded, time-ordered list of prefetch candidates. Each entry is a block address, a secure bit and the time at which it becomes ready. The generator offers at most one candidate per cycle, together with a delay in cycles. The queue turns that delay into a ready time and appends the entry at the young end. A candidate that is already queued is dropped. When the queue is full, the oldest entry is evicted to make room.

Demand accesses also reach the block as training events. A filter decides whether each event qualifies, based on its type, its cacheability and, optionally, whether it missed. A qualifying event cancels any queued entry for the same block. In serial-squash mode it also discards pending entries from the young end. The cache-presence and miss-queue-presence lookups are combinational inputs. Those for the training block come with the event. Those for the head block are answered for the head address that the block exports.

When the cache asks for a prefetch, the head is popped. If that block is already cached or already being fetched, the head is discarded and nothing is sent. Otherwise the block is sent on the next cycle.

Top module: `pf_defer_queue`

## Requirements
- R1: A training event is ignored when it is uncacheable, when it is an instruction fetch while instruction training is off, or when it is a data access while data training is off.
- R2: A data read trains only when read training is on, and a data write only when write training is on. With miss-only mode on, an event trains only if its lookups report the block in neither the cache nor the miss queue.
- R3: Addresses are reduced to block addresses by clearing the low log2(BLK_BYTES) bits. Two entries match only if both the block address and the secure bit are equal. A candidate that matches a queued entry is dropped.
- R4: Inserting into a full queue first discards the head entry and increments `evict_cnt_o` by one. Occupancy never exceeds DEPTH.
- R5: An inserted entry gets ready time `now_i + delay*CYC_TICKS`. `head_ready_o` shows the head entry's ready time, or zero when the queue is empty.
- R6: A qualifying training event whose block and secure bit match a queued entry removes that entry. The remaining entries keep their order.
- R7: With serial squash on, each qualifying training event removes entries from the youngest end while their ready time is greater than or equal to `now_i`. It stops at the first entry with an earlier ready time.
- R8: An issue request pops the head. If either head lookup reports the block present, the head is discarded and `iss_valid_o` stays low. Otherwise, on the next cycle, `iss_valid_o` pulses with the head's block address (low bits zero) and secure bit.
- R9: `mem_req_o` is high exactly when the queue holds at least one entry.
- R10: An issue and an insertion in the same cycle are handled issue first, so a full queue that issues in that cycle evicts nothing.
- R11: After reset the queue is empty, `iss_valid_o` is low and `evict_cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| now_i | input | TIME_W | Current time |
| cfg_train_inst_i | input | 1 | Enable training on instruction fetches |
| cfg_train_data_i | input | 1 | Enable training on data accesses |
| cfg_train_read_i | input | 1 | Enable training on data reads |
| cfg_train_write_i | input | 1 | Enable training on data writes |
| cfg_miss_only_i | input | 1 | Train only on accesses that missed |
| cfg_serial_squash_i | input | 1 | Drop pending young entries on each training event |
| trn_valid_i | input | 1 | Training event present |
| trn_addr_i | input | ADDR_W | Training access address |
| trn_secure_i | input | 1 | Training access secure bit |
| trn_is_inst_i | input | 1 | Training access is an instruction fetch |
| trn_is_write_i | input | 1 | Training data access is a write |
| trn_uncacheable_i | input | 1 | Training access is uncacheable |
| trn_in_cache_i | input | 1 | Training block present in the cache |
| trn_in_missq_i | input | 1 | Training block present in the miss queue |
| cand_valid_i | input | 1 | Prefetch candidate present |
| cand_addr_i | input | ADDR_W | Candidate address |
| cand_secure_i | input | 1 | Candidate secure bit |
| cand_delay_i | input | DELAY_W | Candidate delay in cycles |
| iss_req_i | input | 1 | Request to issue the head entry |
| head_in_cache_i | input | 1 | Head block present in the cache |
| head_in_missq_i | input | 1 | Head block present in the miss queue |
| mem_req_o | output | 1 | Queue non-empty, prefetch wanted |
| head_addr_o | output | ADDR_W | Head block address, for the presence lookups |
| head_secure_o | output | 1 | Head secure bit |
| head_ready_o | output | TIME_W | Head ready time, zero when empty |
| iss_valid_o | output | 1 | Issued prefetch valid |
| iss_addr_o | output | ADDR_W | Issued block address |
| iss_secure_o | output | 1 | Issued secure bit |
| evict_cnt_o | output | EVICT_W | Count of entries evicted by overflow |

## Verification
The following rules are checked on every cycle:
- occupancy never exceeds DEPTH;
- an issue pulse always follows a request made against a present-free head, and carries that head's address;
- the eviction counter moves only when a candidate meets a full queue with no issue in the same cycle;
- an uncacheable event never changes occupancy;
- occupancy grows by at most one, and only on a candidate.

Other behaviours show only in the order in which entries come out, so the bench scenarios cover them:
- which entry a training hit removes;
- where serial squash stops;
- that eviction takes the oldest entry;
- that duplicate filtering respects the secure bit;
- that the issue-before-insert ordering holds.

// File: rtl/pf_dq_pkg.sv
// Shared types for the deferred prefetch queue.
// Assumes nothing beyond the consumers importing it.
package pf_dq_pkg;

    // Outcome of an issue request on the current head entry.
    typedef enum logic [1:0] {
        ISS_IDLE = 2'd0,
        ISS_SEND = 2'd1,
        ISS_DROP = 2'd2
    } iss_act_e;

endpackage

// File: rtl/pf_train_gate.sv
// Decides whether a demand access qualifies as a training event.
// Assumes the presence lookups refer to the training block in this cycle.
module pf_train_gate (
    input  logic valid_i,
    input  logic uncacheable_i,
    input  logic is_inst_i,
    input  logic is_write_i,
    input  logic in_cache_i,
    input  logic in_missq_i,
    input  logic en_inst_i,
    input  logic en_data_i,
    input  logic en_read_i,
    input  logic en_write_i,
    input  logic miss_only_i,
    output logic qualify_o
);

    logic type_ok;
    logic miss_ok;

    // Type filter: instruction fetches, data reads and data writes each need their enables.
    always_comb begin
        if (is_inst_i) type_ok = en_inst_i;
        else           type_ok = en_data_i && (is_write_i ? en_write_i : en_read_i);
    end

    // Miss filter: in miss-only mode the block must be absent from both cache and miss queue.
    always_comb miss_ok = !miss_only_i || (!in_cache_i && !in_missq_i);

    // Final qualification.
    always_comb qualify_o = valid_i && !uncacheable_i && type_ok && miss_ok;

endmodule

// File: rtl/pf_blk_match.sv
// Parallel compare of a key (block + secure) against all valid queue slots.
// Assumes at most one slot matches; reports the lowest matching index.
module pf_blk_match #(
    parameter int DEPTH = 8,
    parameter int BLK_W = 26,
    parameter int CNT_W = 4
) (
    input  logic [BLK_W-1:0] tab_blk_i [DEPTH],
    input  logic             tab_sec_i [DEPTH],
    input  logic [CNT_W-1:0] fill_i,
    input  logic [BLK_W-1:0] key_blk_i,
    input  logic             key_sec_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] idx_o
);

    logic [DEPTH-1:0] eq;

    // One comparator per slot, masked by occupancy.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = (CNT_W'(g) < fill_i) && (tab_blk_i[g] == key_blk_i)
                       && (tab_sec_i[g] == key_sec_i);
    end

    // Priority encode the match vector.
    always_comb begin
        hit_o = |eq;
        idx_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = CNT_W'(i);
        end
    end

endmodule

// File: rtl/pf_defer_queue.sv
// Deferred prefetch request queue. Slot 0 is the head (oldest entry).
// Each cycle: issue on the registered head, then training (cancel + squash),
// then insertion of a new candidate. Assumes the time input does not wrap
// while entries are queued, and that DEPTH >= 2.
module pf_defer_queue
    import pf_dq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int DEPTH     = 8,
    parameter int TIME_W    = 32,
    parameter int DELAY_W   = 8,
    parameter int CYC_TICKS = 1,
    parameter int EVICT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  now_i,
    input  logic               cfg_train_inst_i,
    input  logic               cfg_train_data_i,
    input  logic               cfg_train_read_i,
    input  logic               cfg_train_write_i,
    input  logic               cfg_miss_only_i,
    input  logic               cfg_serial_squash_i,
    input  logic               trn_valid_i,
    input  logic [ADDR_W-1:0]  trn_addr_i,
    input  logic               trn_secure_i,
    input  logic               trn_is_inst_i,
    input  logic               trn_is_write_i,
    input  logic               trn_uncacheable_i,
    input  logic               trn_in_cache_i,
    input  logic               trn_in_missq_i,
    input  logic               cand_valid_i,
    input  logic [ADDR_W-1:0]  cand_addr_i,
    input  logic               cand_secure_i,
    input  logic [DELAY_W-1:0] cand_delay_i,
    input  logic               iss_req_i,
    input  logic               head_in_cache_i,
    input  logic               head_in_missq_i,
    output logic               mem_req_o,
    output logic [ADDR_W-1:0]  head_addr_o,
    output logic               head_secure_o,
    output logic [TIME_W-1:0]  head_ready_o,
    output logic               iss_valid_o,
    output logic [ADDR_W-1:0]  iss_addr_o,
    output logic               iss_secure_o,
    output logic [EVICT_W-1:0] evict_cnt_o
);

    localparam int OFS_W = $clog2(BLK_BYTES);
    localparam int BLK_W = ADDR_W - OFS_W;
    localparam int CNT_W = $clog2(DEPTH + 1);

    // Registered queue state.
    logic [BLK_W-1:0]  blk_q [DEPTH];
    logic              sec_q [DEPTH];
    logic [TIME_W-1:0] rdy_q [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic              iss_valid_q;
    logic [BLK_W-1:0]  iss_blk_q;
    logic              iss_sec_q;
    logic [EVICT_W-1:0] evict_q;

    // Stage 1 (after issue), stage 2 (after training), next state (after insert).
    logic [BLK_W-1:0]  s1_blk [DEPTH];
    logic              s1_sec [DEPTH];
    logic [TIME_W-1:0] s1_rdy [DEPTH];
    logic [CNT_W-1:0]  s1_cnt;
    logic [BLK_W-1:0]  s2_blk [DEPTH];
    logic              s2_sec [DEPTH];
    logic [TIME_W-1:0] s2_rdy [DEPTH];
    logic [CNT_W-1:0]  s2_cnt;
    logic [BLK_W-1:0]  nx_blk [DEPTH];
    logic              nx_sec [DEPTH];
    logic [TIME_W-1:0] nx_rdy [DEPTH];
    logic [CNT_W-1:0]  nx_cnt;

    iss_act_e          iss_act;
    logic              trn_qual;
    logic              trn_hit;
    logic [CNT_W-1:0]  trn_idx;
    logic              cand_hit;
    logic [CNT_W-1:0]  cand_idx;
    logic              evict_now;
    logic [BLK_W-1:0]  trn_blk;
    logic [BLK_W-1:0]  cand_blk;
    logic [TIME_W-1:0] cand_rdy;

    assign trn_blk  = trn_addr_i[ADDR_W-1:OFS_W];
    assign cand_blk = cand_addr_i[ADDR_W-1:OFS_W];
    assign cand_rdy = now_i + TIME_W'(cand_delay_i) * TIME_W'(CYC_TICKS);

    pf_train_gate u_gate (
        .valid_i       (trn_valid_i),
        .uncacheable_i (trn_uncacheable_i),
        .is_inst_i     (trn_is_inst_i),
        .is_write_i    (trn_is_write_i),
        .in_cache_i    (trn_in_cache_i),
        .in_missq_i    (trn_in_missq_i),
        .en_inst_i     (cfg_train_inst_i),
        .en_data_i     (cfg_train_data_i),
        .en_read_i     (cfg_train_read_i),
        .en_write_i    (cfg_train_write_i),
        .miss_only_i   (cfg_miss_only_i),
        .qualify_o     (trn_qual)
    );

    // Stage 1: pop the head on an issue request and classify it.
    always_comb begin
        s1_blk  = blk_q;
        s1_sec  = sec_q;
        s1_rdy  = rdy_q;
        s1_cnt  = cnt_q;
        iss_act = ISS_IDLE;
        if (iss_req_i && cnt_q != '0) begin
            iss_act = (head_in_cache_i || head_in_missq_i) ? ISS_DROP : ISS_SEND;
            for (int i = 0; i < DEPTH - 1; i++) begin
                s1_blk[i] = blk_q[i+1];
                s1_sec[i] = sec_q[i+1];
                s1_rdy[i] = rdy_q[i+1];
            end
            s1_cnt = cnt_q - CNT_W'(1);
        end
    end

    pf_blk_match #(.DEPTH(DEPTH), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_trn_match (
        .tab_blk_i (s1_blk),
        .tab_sec_i (s1_sec),
        .fill_i    (s1_cnt),
        .key_blk_i (trn_blk),
        .key_sec_i (trn_secure_i),
        .hit_o     (trn_hit),
        .idx_o     (trn_idx)
    );

    // Stage 2: cancel the matching entry, then optionally squash young pending entries.
    always_comb begin
        logic stop;
        s2_blk = s1_blk;
        s2_sec = s1_sec;
        s2_rdy = s1_rdy;
        s2_cnt = s1_cnt;
        stop   = 1'b0;
        if (trn_qual && trn_hit) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(trn_idx)) begin
                    s2_blk[i] = s1_blk[i+1];
                    s2_sec[i] = s1_sec[i+1];
                    s2_rdy[i] = s1_rdy[i+1];
                end
            end
            s2_cnt = s1_cnt - CNT_W'(1);
        end
        if (trn_qual && cfg_serial_squash_i) begin
            for (int i = DEPTH - 1; i >= 0; i--) begin
                if (!stop && i < int'(s2_cnt)) begin
                    if (s2_rdy[i] >= now_i) s2_cnt = CNT_W'(i);
                    else                    stop   = 1'b1;
                end
            end
        end
    end

    pf_blk_match #(.DEPTH(DEPTH), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_cand_match (
        .tab_blk_i (s2_blk),
        .tab_sec_i (s2_sec),
        .fill_i    (s2_cnt),
        .key_blk_i (cand_blk),
        .key_sec_i (cand_secure_i),
        .hit_o     (cand_hit),
        .idx_o     (cand_idx)
    );

    // Stage 3: append a non-duplicate candidate, evicting the head when full.
    always_comb begin
        nx_blk    = s2_blk;
        nx_sec    = s2_sec;
        nx_rdy    = s2_rdy;
        nx_cnt    = s2_cnt;
        evict_now = 1'b0;
        if (cand_valid_i && !cand_hit) begin
            if (s2_cnt == CNT_W'(DEPTH)) begin
                evict_now = 1'b1;
                for (int i = 0; i < DEPTH - 1; i++) begin
                    nx_blk[i] = s2_blk[i+1];
                    nx_sec[i] = s2_sec[i+1];
                    nx_rdy[i] = s2_rdy[i+1];
                end
                nx_cnt = s2_cnt - CNT_W'(1);
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (i == int'(nx_cnt)) begin
                    nx_blk[i] = cand_blk;
                    nx_sec[i] = cand_secure_i;
                    nx_rdy[i] = cand_rdy;
                end
            end
            nx_cnt = nx_cnt + CNT_W'(1);
        end
    end

    // State register: queue contents, issue output and eviction count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                blk_q[i] <= '0;
                sec_q[i] <= 1'b0;
                rdy_q[i] <= '0;
            end
            cnt_q       <= '0;
            iss_valid_q <= 1'b0;
            iss_blk_q   <= '0;
            iss_sec_q   <= 1'b0;
            evict_q     <= '0;
        end else begin
            blk_q       <= nx_blk;
            sec_q       <= nx_sec;
            rdy_q       <= nx_rdy;
            cnt_q       <= nx_cnt;
            iss_valid_q <= (iss_act == ISS_SEND);
            if (iss_act == ISS_SEND) begin
                iss_blk_q <= blk_q[0];
                iss_sec_q <= sec_q[0];
            end
            if (evict_now) evict_q <= evict_q + EVICT_W'(1);
        end
    end

    // Output drive.
    assign mem_req_o     = (cnt_q != '0);
    assign head_addr_o   = {blk_q[0], {OFS_W{1'b0}}};
    assign head_secure_o = sec_q[0];
    assign head_ready_o  = mem_req_o ? rdy_q[0] : '0;
    assign iss_valid_o   = iss_valid_q;
    assign iss_addr_o    = {iss_blk_q, {OFS_W{1'b0}}};
    assign iss_secure_o  = iss_sec_q;
    assign evict_cnt_o   = evict_q;

endmodule

// File: rtl/pf_defer_queue_chk.sv
// Temporal checks for pf_defer_queue, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module pf_defer_queue_chk #(
    parameter int ADDR_W  = 32,
    parameter int DEPTH   = 8,
    parameter int CNT_W   = 4,
    parameter int EVICT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trn_valid_i,
    input logic               trn_uncacheable_i,
    input logic               cand_valid_i,
    input logic               iss_req_i,
    input logic               head_in_cache_i,
    input logic               head_in_missq_i,
    input logic               mem_req_o,
    input logic [ADDR_W-1:0]  head_addr_o,
    input logic               iss_valid_o,
    input logic [ADDR_W-1:0]  iss_addr_o,
    input logic [EVICT_W-1:0] evict_cnt_o,
    input logic [CNT_W-1:0]   cnt_q
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R4

    AST_ISSUE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid_o |-> $past(iss_req_i && mem_req_o && !head_in_cache_i && !head_in_missq_i)); // R8

    AST_ISSUE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid_o |-> (iss_addr_o == $past(head_addr_o))); // R8

    AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_cnt_o != $past(evict_cnt_o)) |->
            $past(cand_valid_i && cnt_q == CNT_W'(DEPTH) && !iss_req_i)); // R10

    AST_UNCACHE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_valid_i && trn_uncacheable_i && !cand_valid_i && !iss_req_i) |=>
            $stable(cnt_q)); // R1

    AST_GROW_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > $past(cnt_q)) |->
            (cnt_q == $past(cnt_q) + CNT_W'(1) && $past(cand_valid_i))); // R3

endmodule

bind pf_defer_queue pf_defer_queue_chk #(
    .ADDR_W  (ADDR_W),
    .DEPTH   (DEPTH),
    .CNT_W   (CNT_W),
    .EVICT_W (EVICT_W)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .trn_valid_i       (trn_valid_i),
    .trn_uncacheable_i (trn_uncacheable_i),
    .cand_valid_i      (cand_valid_i),
    .iss_req_i         (iss_req_i),
    .head_in_cache_i   (head_in_cache_i),
    .head_in_missq_i   (head_in_missq_i),
    .mem_req_o         (mem_req_o),
    .head_addr_o       (head_addr_o),
    .iss_valid_o       (iss_valid_o),
    .iss_addr_o        (iss_addr_o),
    .evict_cnt_o       (evict_cnt_o),
    .cnt_q             (cnt_q)
);

// File: tb/tb_pf_defer_queue.sv
// Scoreboard bench: driver tasks queue expected issues, a monitor compares them.
module tb_pf_defer_queue;

    localparam int ADDR_W = 32;
    localparam int TIME_W = 16;
    localparam int DELAY_W = 4;
    localparam int EVICT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TIME_W-1:0] now_i = '0;
    logic cfg_inst = 1'b1, cfg_data = 1'b1, cfg_rd = 1'b1, cfg_wr = 1'b1;
    logic cfg_miss = 1'b0, cfg_sq = 1'b0;
    logic trn_valid = 1'b0, trn_sec = 1'b0, trn_inst = 1'b0, trn_wr = 1'b0;
    logic trn_unc = 1'b0, trn_inc = 1'b0, trn_inm = 1'b0;
    logic [ADDR_W-1:0] trn_addr = '0;
    logic cand_valid = 1'b0, cand_sec = 1'b0;
    logic [ADDR_W-1:0] cand_addr = '0;
    logic [DELAY_W-1:0] cand_dly = '0;
    logic iss_req = 1'b0, h_inc = 1'b0, h_inm = 1'b0;
    logic mem_req_o, head_secure_o, iss_valid_o, iss_secure_o;
    logic [ADDR_W-1:0] head_addr_o, iss_addr_o;
    logic [TIME_W-1:0] head_ready_o;
    logic [EVICT_W-1:0] evict_cnt_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [ADDR_W-1:0] a;
        logic              s;
        string             r;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    pf_defer_queue #(
        .ADDR_W(ADDR_W), .BLK_BYTES(64), .DEPTH(4), .TIME_W(TIME_W),
        .DELAY_W(DELAY_W), .CYC_TICKS(2), .EVICT_W(EVICT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .now_i(now_i),
        .cfg_train_inst_i(cfg_inst), .cfg_train_data_i(cfg_data),
        .cfg_train_read_i(cfg_rd), .cfg_train_write_i(cfg_wr),
        .cfg_miss_only_i(cfg_miss), .cfg_serial_squash_i(cfg_sq),
        .trn_valid_i(trn_valid), .trn_addr_i(trn_addr), .trn_secure_i(trn_sec),
        .trn_is_inst_i(trn_inst), .trn_is_write_i(trn_wr),
        .trn_uncacheable_i(trn_unc), .trn_in_cache_i(trn_inc),
        .trn_in_missq_i(trn_inm), .cand_valid_i(cand_valid),
        .cand_addr_i(cand_addr), .cand_secure_i(cand_sec),
        .cand_delay_i(cand_dly), .iss_req_i(iss_req),
        .head_in_cache_i(h_inc), .head_in_missq_i(h_inm),
        .mem_req_o(mem_req_o), .head_addr_o(head_addr_o),
        .head_secure_o(head_secure_o), .head_ready_o(head_ready_o),
        .iss_valid_o(iss_valid_o), .iss_addr_o(iss_addr_o),
        .iss_secure_o(iss_secure_o), .evict_cnt_o(evict_cnt_o)
    );

    // Record one check.
    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs set before are applied at the edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic [ADDR_W-1:0] a, input logic s, input int d);
        cand_valid = 1'b1; cand_addr = a; cand_sec = s; cand_dly = DELAY_W'(d);
        step();
        cand_valid = 1'b0;
    endtask

    task automatic train(input logic [ADDR_W-1:0] a, input logic s, input logic unc,
                         input logic inst, input logic wr, input logic inc,
                         input logic inm);
        trn_valid = 1'b1; trn_addr = a; trn_sec = s; trn_unc = unc;
        trn_inst = inst; trn_wr = wr; trn_inc = inc; trn_inm = inm;
        step();
        trn_valid = 1'b0; trn_unc = 1'b0; trn_inst = 1'b0; trn_wr = 1'b0;
        trn_inc = 1'b0; trn_inm = 1'b0; trn_sec = 1'b0;
    endtask

    // Driver: pop the head expecting it to be sent.
    task automatic pop_send(input logic [ADDR_W-1:0] a, input logic s, input string r);
        exp_t e;
        e.a = a; e.s = s; e.r = r;
        exp_q.push_back(e);
        iss_req = 1'b1;
        step();
        iss_req = 1'b0;
    endtask

    // Drain check: every expected issue seen and the queue empty.
    task automatic drained(input string r);
        step();
        chk(exp_q.size() == 0, r, 64'(exp_q.size()), 64'd0);
        chk(mem_req_o == 1'b0, "R9", 64'(mem_req_o), 64'd0);
    endtask

    // Monitor: compare each issue pulse against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && iss_valid_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", 64'(iss_addr_o), 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(iss_addr_o == e.a && iss_secure_o == e.s, e.r,
                    {31'd0, iss_secure_o, iss_addr_o}, {31'd0, e.s, e.a});
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [EVICT_W-1:0] ev0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(mem_req_o == 1'b0, "R11", 64'(mem_req_o), 64'd0);
        chk(iss_valid_o == 1'b0, "R11", 64'(iss_valid_o), 64'd0);
        chk(evict_cnt_o == '0, "R11", 64'(evict_cnt_o), 64'd0);
        chk(head_ready_o == '0, "R11", 64'(head_ready_o), 64'd0);

        // R5 ready time, R3 duplicate and secure matching
        now_i = 16'd10;
        put(32'h1000, 1'b0, 3);
        chk(head_ready_o == 16'd16, "R5", 64'(head_ready_o), 64'd16);
        chk(mem_req_o == 1'b1, "R9", 64'(mem_req_o), 64'd1);
        put(32'h1010, 1'b0, 1);
        put(32'h1000, 1'b1, 1);
        chk(head_ready_o == 16'd16, "R3", 64'(head_ready_o), 64'd16);
        pop_send(32'h1000, 1'b0, "R3");
        pop_send(32'h1000, 1'b1, "R3");
        drained("R3");
        chk(head_ready_o == '0, "R5", 64'(head_ready_o), 64'd0);

        // R4 overflow evicts oldest
        for (int i = 0; i < 5; i++) put(32'h2000 + 32'(i) * 32'h40, 1'b0, 1);
        chk(evict_cnt_o == 8'd1, "R4", 64'(evict_cnt_o), 64'd1);
        chk(head_addr_o == 32'h2040, "R4", 64'(head_addr_o), 64'h2040);
        for (int i = 1; i < 5; i++) pop_send(32'h2000 + 32'(i) * 32'h40, 1'b0, "R4");
        drained("R4");

        // R1/R2 ignored events, R6 removal keeps order
        for (int i = 0; i < 4; i++) put(32'h3000 + 32'(i) * 32'h40, 1'b0, 1);
        train(32'h3000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(head_addr_o == 32'h3000, "R1", 64'(head_addr_o), 64'h3000);
        cfg_inst = 1'b0;
        train(32'h3000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(head_addr_o == 32'h3000, "R1", 64'(head_addr_o), 64'h3000);
        cfg_inst = 1'b1; cfg_data = 1'b0;
        train(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(head_addr_o == 32'h3000, "R1", 64'(head_addr_o), 64'h3000);
        cfg_data = 1'b1; cfg_wr = 1'b0;
        train(32'h3000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(head_addr_o == 32'h3000, "R2", 64'(head_addr_o), 64'h3000);
        cfg_wr = 1'b1; cfg_rd = 1'b0;
        train(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(head_addr_o == 32'h3000, "R2", 64'(head_addr_o), 64'h3000);
        cfg_rd = 1'b1; cfg_miss = 1'b1;
        train(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(head_addr_o == 32'h3000, "R2", 64'(head_addr_o), 64'h3000);
        train(32'h3000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(head_addr_o == 32'h3000, "R2", 64'(head_addr_o), 64'h3000);
        train(32'h3000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(head_addr_o == 32'h3000, "R3", 64'(head_addr_o), 64'h3000);
        train(32'h30C0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        cfg_miss = 1'b0;
        train(32'h3050, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        pop_send(32'h3000, 1'b0, "R6");
        pop_send(32'h3080, 1'b0, "R6");
        drained("R6");

        // R7 serial squash from the young end
        now_i = 16'd20;
        put(32'h4000, 1'b0, 1);
        put(32'h4040, 1'b0, 2);
        put(32'h4080, 1'b0, 3);
        chk(head_ready_o == 16'd22, "R5", 64'(head_ready_o), 64'd22);
        now_i = 16'd25; cfg_sq = 1'b1;
        train(32'h9000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cfg_sq = 1'b0;
        pop_send(32'h4000, 1'b0, "R7");
        pop_send(32'h4040, 1'b0, "R7");
        drained("R7");

        // R8 present head is dropped without issue
        put(32'h5000, 1'b1, 1);
        put(32'h5040, 1'b0, 1);
        iss_req = 1'b1; h_inc = 1'b1;
        step();
        iss_req = 1'b0; h_inc = 1'b0;
        chk(iss_valid_o == 1'b0, "R8", 64'(iss_valid_o), 64'd0);
        iss_req = 1'b1; h_inm = 1'b1;
        step();
        iss_req = 1'b0; h_inm = 1'b0;
        chk(iss_valid_o == 1'b0, "R8", 64'(iss_valid_o), 64'd0);
        drained("R8");

        // R10 issue before insert on a full queue
        for (int i = 0; i < 4; i++) put(32'h6000 + 32'(i) * 32'h40, 1'b0, 1);
        ev0 = evict_cnt_o;
        begin
            exp_t e;
            e.a = 32'h6000; e.s = 1'b0; e.r = "R10";
            exp_q.push_back(e);
        end
        iss_req = 1'b1; cand_valid = 1'b1; cand_addr = 32'h6100; cand_sec = 1'b0;
        cand_dly = 4'd1;
        step();
        iss_req = 1'b0; cand_valid = 1'b0;
        chk(evict_cnt_o == ev0, "R10", 64'(evict_cnt_o), 64'(ev0));
        for (int i = 1; i < 5; i++) pop_send(32'h6000 + 32'(i) * 32'h40, 1'b0, "R10");
        drained("R10");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule